// File: doc/BRIEF.md
# PCM Serial Port with Framed Shift-In and Recirculating Shift-Out

This block is the 8-bit PCM side of a transcoder's serial interface. A frame strobe marks the window in which serial traffic happens, a direction select decides whether that window carries a sample in, and a separate PCM bit clock moves the bits. While the strobe and the direction select are both high, each falling edge of the bit clock shifts one bit of serial input into a word register. When the strobe falls with the direction select high, the most recent 8 bits go to the core on a parallel port with a one-cycle valid pulse.

On the same strobe falling edge, the core's decoded word is loaded into a parallel-to-serial register. At the next strobe rising edge its MSB appears on the serial output. Each rising bit-clock edge inside the strobe-high window then presents the next lower bit. Once the LSB has gone out, the next rising edge starts again at the MSB, so extra clocks recirculate the word. The serial clock should be high whenever the strobe changes. A strobe edge seen while the clock is low raises a protocol-error pulse.

All serial inputs are levels sampled by the system clock `clk`. An edge of the bit clock or the strobe is recognised at the first `clk` rising edge where the sampled level differs from the one before. A control state machine has two states. `ST_IDLE` (strobe low) moves to `ST_WINDOW` on the transition *open* (strobe rise). `ST_WINDOW` returns to `ST_IDLE` on the transition *close* (strobe fall).

Top module: `pcm_serial_port`

## Requirements
- R1: A bit of `sdi` is shifted into the input word, entering at bit 0 and moving earlier bits towards bit 7, only on a falling `sclk` edge while both `strobe` and `dir_in` are high. Other `sclk` falling edges change nothing.
- R2: On a falling `strobe` edge with `dir_in` high, `rx_data` takes the last 8 bits shifted in, with the first of those 8 bits in bit 7, and `rx_valid` is high for exactly one `clk` cycle. On a falling `strobe` edge with `dir_in` low, `rx_data` keeps its value and `rx_valid` stays low.
- R3: `rst_n` low clears the input word, `rx_data`, `rx_valid`, `sdo`, `proto_err` and the output word to 0 at once, without waiting for `clk`.
- R4: Every falling `strobe` edge, whatever the level of `dir_in`, loads `tx_data` into the output word.
- R5: On a rising `strobe` edge, `sdo` takes bit 7 of the output word.
- R6: Each rising `sclk` edge while `strobe` is high presents the next lower bit on `sdo`. After bit 0 has been presented, the next rising edge presents bit 7 again, which is the eighth rising edge in the window.
- R7: `sdo` changes only on a rising `strobe` edge or on a rising `sclk` edge while `strobe` is high. It holds its value outside the window and ignores `sclk` while `strobe` is low.
- R8: A `strobe` edge recognised while `sclk` is low makes `proto_err` high for the following `clk` cycle. Otherwise `proto_err` is low.
- R9: Outputs update at the same `clk` rising edge at which the input edge is first recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | PCM bit clock level |
| strobe | input | 1 | Frame strobe level |
| dir_in | input | 1 | Direction select: high means the window carries an input sample |
| sdi | input | 1 | Serial data in |
| tx_data | input | 8 | Decoded word from the core for serial output |
| sdo | output | 1 | Serial data out |
| rx_data | output | 8 | Received word handed to the core |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| proto_err | output | 1 | Pulse for a strobe edge taken while `sclk` is low |

## Verification
The bench builds the block with its default word width of 8. With that width, an eleven-clock window pushes the serializer past bit 0 and into its recirculation, and the same window leaves surplus input bits for the latch to discard. Windows with the direction select low, bit clocks while the strobe is low, and strobe edges taken with the clock low reach the gating and error paths. A mid-frame asynchronous reset confirms that every stored word returns to zero.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_WINDOW = 1'b1
    } win_state_e;

    localparam int SIG_SCLK   = 0;
    localparam int SIG_STROBE = 1;
    localparam int SIG_COUNT  = 2;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
    parameter int             N       = 2,
    parameter logic [N-1:0]   RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_sig
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= RST_LVL[g];
            else        prev_q[g] <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev_q[g];
        assign fall[g] = ~lvl[g] & prev_q[g];
    end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdi,
    output logic [WIDTH-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WIDTH-2:0], sdi};
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] par_in,
    input  logic             start,
    input  logic             step,
    output logic             sdo
);
    localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [PW-1:0] PTR_TOP  = PW'(WIDTH - 1);
    localparam logic [PW-1:0] PTR_NEXT = PW'(WIDTH - 2);

    logic [WIDTH-1:0] word;
    logic [PW-1:0]    ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word <= '0;
        else if (load) word <= par_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo <= 1'b0;
            ptr <= PTR_TOP;
        end else if (start) begin
            sdo <= word[WIDTH-1];
            ptr <= PTR_NEXT;
        end else if (step) begin
            sdo <= word[ptr];
            ptr <= (ptr == '0) ? PTR_TOP : ptr - 1'b1;
        end
    end

    // R4: a load places the core word in the serializer
    a_r4_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> word == $past(par_in));

    // R5: the window start presents the top bit
    a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !load) |=> sdo == $past(word[WIDTH-1]));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             strobe,
    input  logic             dir_in,
    input  logic             sdi,
    input  logic [WIDTH-1:0] tx_data,
    output logic             sdo,
    output logic [WIDTH-1:0] rx_data,
    output logic             rx_valid,
    output logic             proto_err
);
    localparam logic [SIG_COUNT-1:0] IDLE_LVL = SIG_COUNT'(1 << SIG_SCLK);

    logic [SIG_COUNT-1:0] lvl, rise, fall;
    logic sclk_rise, sclk_fall, open_evt, close_evt;
    logic shift_en, tx_step;
    logic [WIDTH-1:0] rx_word;
    win_state_e state_q, state_d;

    assign lvl[SIG_SCLK]   = sclk;
    assign lvl[SIG_STROBE] = strobe;

    pcm_edge_det #(.N(SIG_COUNT), .RST_LVL(IDLE_LVL)) i_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    assign sclk_rise = rise[SIG_SCLK];
    assign sclk_fall = fall[SIG_SCLK];
    assign open_evt  = rise[SIG_STROBE];
    assign close_evt = fall[SIG_STROBE];

    assign shift_en = sclk_fall && strobe && dir_in;
    assign tx_step  = sclk_rise && strobe;

    pcm_rx_shift #(.WIDTH(WIDTH)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdi      (sdi),
        .word     (rx_word)
    );

    pcm_tx_serializer #(.WIDTH(WIDTH)) i_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (close_evt),
        .par_in (tx_data),
        .start  (open_evt),
        .step   (tx_step),
        .sdo    (sdo)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (open_evt)  state_d = ST_WINDOW;
            ST_WINDOW: if (close_evt) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            proto_err <= (open_evt || close_evt) && !sclk;
            if (state_q == ST_WINDOW && close_evt && dir_in) begin
                rx_data  <= rx_word;
                rx_valid <= 1'b1;
            end
        end
    end

    // R1: the input word moves only on a gated falling bit-clock edge
    a_r1_gated_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_fall && strobe && dir_in) |=> $stable(rx_word));

    // R2: the hand-over strobe never lasts two cycles
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: without an opening or a bit-clock rise the output pin holds
    a_r7_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !open_evt) |=> $stable(sdo));

    // R8: no error unless a strobe edge met a low bit clock
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !((open_evt || close_evt) && !sclk) |=> !proto_err);
endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, strobe = 1'b0, dir_in = 1'b0, sdi = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic sdo, rx_valid, proto_err;
    logic [W-1:0] rx_data;

    int tests = 0, fails = 0, valids = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pcm_serial_port #(.WIDTH(W)) i_pcm_serial_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .strobe(strobe),
        .dir_in(dir_in), .sdi(sdi), .tx_data(tx_data), .sdo(sdo),
        .rx_data(rx_data), .rx_valid(rx_valid), .proto_err(proto_err)
    );

    // behavioural reference
    bit q[$];
    logic [W-1:0] m_tx, e_data;
    logic e_sdo, e_valid, e_err;
    int m_idx;
    logic m_psclk, m_pstb;

    function automatic logic [W-1:0] last_bits();
        logic [W-1:0] v = '0;
        for (int i = 0; i < W; i++) begin
            int k = q.size() - 1 - i;
            if (k >= 0) v[i] = q[k];
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            m_tx = '0; e_data = '0; e_sdo = 0; e_valid = 0; e_err = 0;
            m_idx = W - 1; m_psclk = 1; m_pstb = 0;
        end else begin
            bit sr, sf, br, bf;
            sr = sclk && !m_psclk;  sf = !sclk && m_psclk;
            br = strobe && !m_pstb; bf = !strobe && m_pstb;
            if (br) begin
                e_sdo = m_tx[W-1]; m_idx = W - 2;
            end else if (sr && strobe) begin
                e_sdo = m_tx[m_idx];
                m_idx = (m_idx == 0) ? W - 1 : m_idx - 1;
            end
            if (sf && strobe && dir_in) q.push_back(sdi);
            e_valid = 0;
            if (bf) begin
                if (dir_in) begin e_data = last_bits(); e_valid = 1; end
                m_tx = tx_data;
            end
            e_err = (br || bf) && !sclk;
            m_psclk = sclk; m_pstb = strobe;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) if (rst_n && !done) begin
        chk(sdo == e_sdo, "R5/R6/R7 sdo", sdo, e_sdo);
        chk(rx_data == e_data, "R1/R2 rx_data", rx_data, e_data);
        chk(rx_valid == e_valid, "R2/R9 rx_valid", rx_valid, e_valid);
        chk(proto_err == e_err, "R8 proto_err", proto_err, e_err);
    end

    always @(posedge clk) if (rx_valid) valids++;

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic d);
        @(negedge clk); sdi = d; sclk = 0;
        gap(2);
        sclk = 1;
        gap(1);
    endtask

    task automatic frame(input logic d, input logic [15:0] pat, input int n,
                         input logic [W-1:0] next_out);
        @(negedge clk); dir_in = d; strobe = 1;
        gap(2);
        for (int i = 0; i < n; i++) pulse(pat[n-1-i]);
        tx_data = next_out;
        @(negedge clk); strobe = 0;
        gap(3);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        gap(3);
        // R3: values while reset is held
        chk(sdo == 0 && rx_data == 0 && !rx_valid && !proto_err, "R3 reset state",
            {sdo, rx_valid, proto_err, rx_data}, 0);
        rst_n = 1;
        gap(2);
        // load first output word; R4
        frame(1, 16'h0000, 0, 8'h3C);
        chk(valids == 1, "R2 empty window valid count", valids, 1);
        // R1/R2: eight bits in, word A5 out
        frame(1, 16'h00A5, 8, 8'h96);
        chk(rx_data == 8'hA5, "R2 eight-bit capture", rx_data, 8'hA5);
        // R6: eleven clocks recirculate; last 8 of 11 bits kept
        frame(1, 16'b101_1100_1011, 11, 8'h5A);
        chk(rx_data == 8'hCB, "R2 surplus bits dropped", rx_data, 8'hCB);
        // R1/R2: direction low, input ignored, no hand-over
        frame(0, 16'h00FF, 8, 8'hE1);
        chk(rx_data == 8'hCB, "R1 dir low leaves data", rx_data, 8'hCB);
        chk(valids == 3, "R2 no valid with dir low", valids, 3);
        // R7: bit clocks with strobe low
        for (int i = 0; i < 4; i++) pulse(1'b1);
        // R8: strobe edges taken with clock low
        @(negedge clk); sclk = 0; gap(1); dir_in = 1; strobe = 1;
        @(negedge clk);
        chk(proto_err == 1, "R8 error on open", proto_err, 1);
        gap(1); sclk = 1; gap(2);
        pulse(1'b0); pulse(1'b1); pulse(1'b1);
        sclk = 0; gap(1); strobe = 0;
        @(negedge clk);
        chk(proto_err == 1, "R8 error on close", proto_err, 1);
        gap(1); sclk = 1; gap(2);
        frame(1, 16'h0033, 8, 8'h00);
        // R3: asynchronous reset mid-window
        @(negedge clk); strobe = 1; gap(2); pulse(1'b1); pulse(1'b0);
        #2 rst_n = 0; #1;
        chk(sdo == 0 && rx_data == 0 && !rx_valid, "R3 async clear",
            {sdo, rx_data}, 0);
        strobe = 0; sclk = 1;
        gap(2); rst_n = 1; gap(2);
        frame(1, 16'h0000, 0, 8'h00);
        chk(rx_data == 8'h00, "R3 input word cleared", rx_data, 0);
        frame(1, 16'h0000, 8, 8'h00);
        gap(4);
        finish_run();
    end
endmodule